// File: doc/BRIEF.md
# Quadrature Sine-Cosine Loop Analyzer

This block measures one point of a control loop's frequency response. A recursive two-state oscillator produces a sine and a cosine sequence at a frequency set by a programmable coefficient. The sine goes out as an excitation sample that the loop adds at its injection point. The measured loop signal is multiplied by the same sine and the same cosine, and the products are summed over a window of a chosen number of samples. This yields the in-phase (real) and quadrature (imaginary) correlation sums.

A sweep controller pulses the start input once per frequency, with the coefficient, amplitude and window length on the inputs. It then strobes one sample per control period and waits for the done pulse. About fifty such measurements make a sweep. Turning the two sums into gain and phase is left to the consumer.

Top module: `loop_analyzer`

## Requirements
- R1: After reset, exc_o, re_o and im_o are zero and done_o and busy_o are low.
- R2: In the cycle after start_i is sampled high, busy_o is high and exc_o, re_o and im_o are all zero. The sine state is reloaded to 0 and the cosine state to amp_i.
- R3: On each accepted sample the oscillator advances as s' = s + floor(k*c / 2^14) and then c' = c - floor(k*s' / 2^14). All values are signed 16-bit with 14 fraction bits and wrap to 16 bits. While busy, exc_o shows the current s.
- R4: coef_i, amp_i and win_len_i are captured only at start_i. Changing them during a window has no effect on the result.
- R5: A sample is accepted when sample_i is high, busy_o is high and start_i is low. Each accepted sample adds meas_i*s to re_o and meas_i*c to im_o, using the s and c in effect before the step. Cycles without an accepted sample leave re_o, im_o and exc_o unchanged.
- R6: done_o is high for exactly one cycle. It comes in the cycle after the win_len-th accepted sample, and busy_o falls in that same cycle.
- R7: While idle, exc_o is zero and sample strobes leave re_o and im_o unchanged, so the results hold until the next start.
- R8: A start during a window abandons it and begins a fresh measurement with the new settings.
- R9: The sums cannot overflow, even with full-scale inputs over the longest window (win_len = 2^WIN_W - 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a measurement with the present settings |
| sample_i | input | 1 | One control-period sample strobe |
| coef_i | input | DATA_W | Oscillator frequency coefficient, signed Q1.14 |
| amp_i | input | DATA_W | Excitation amplitude, signed Q1.14 |
| win_len_i | input | WIN_W | Samples per measurement, at least 1 |
| meas_i | input | DATA_W | Measured loop signal, signed |
| exc_o | output | DATA_W | Excitation sample to inject |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse when sums are final |
| re_o | output | ACC_W | In-phase correlation sum |
| im_o | output | ACC_W | Quadrature correlation sum |

## Verification
The assertions assume win_len_i is at least one whenever start_i is pulsed. They also assume amp_i and coef_i are small enough that the oscillator states stay inside the 16-bit range. The stimulus uses amplitudes at or below one in Q1.14 and coefficients well below one, and it always loads non-zero window lengths. meas_i may take any value, including the most negative code, to stress the overflow margin.

// File: rtl/loop_analyzer_pkg.sv
package loop_analyzer_pkg;
  localparam int unsigned LA_DATA_W = 16;
  localparam int unsigned LA_FRAC_W = 14;
  localparam int unsigned LA_WIN_W  = 12;
  localparam int unsigned LA_NCH    = 2;   // in-phase, quadrature
endpackage

// File: rtl/la_osc.sv
module la_osc #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     step_i,
  input  logic signed [DATA_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] amp_i,
  output logic signed [DATA_W-1:0] sin_o,
  output logic signed [DATA_W-1:0] cos_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] k_q, s_q, c_q, s_nxt, c_nxt;
  logic signed [PROD_W-1:0] kc, ks;

  always_comb begin
    kc    = k_q * c_q;
    s_nxt = s_q + DATA_W'(kc >>> FRAC_W);
    ks    = k_q * s_nxt;              // uses updated sine
    c_nxt = c_q - DATA_W'(ks >>> FRAC_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0;
      s_q <= '0;
      c_q <= '0;
    end else if (load_i) begin
      k_q <= coef_i;
      s_q <= '0;
      c_q <= amp_i;
    end else if (step_i) begin
      s_q <= s_nxt;
      c_q <= c_nxt;
    end
  end

  assign sin_o = s_q;
  assign cos_o = c_q;
endmodule

// File: rtl/la_mac.sv
module la_mac #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 44
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [2*DATA_W-1:0] prod;
  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clr_i)   acc_o <= '0;
    else if (en_i)    acc_o <= acc_o + ACC_W'(prod);
  end
endmodule

// File: rtl/la_win.sv
module la_win #(
  parameter int unsigned WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             last_o
);
  logic [WIN_W-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      len_q <= len_i;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == len_q - 1'b1);
endmodule

// File: rtl/loop_analyzer.sv
module loop_analyzer
  import loop_analyzer_pkg::*;
#(
  parameter int unsigned DATA_W = LA_DATA_W,
  parameter int unsigned FRAC_W = LA_FRAC_W,
  parameter int unsigned WIN_W  = LA_WIN_W,
  localparam int unsigned ACC_W = 2 * DATA_W + WIN_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     sample_i,
  input  logic signed [DATA_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] amp_i,
  input  logic        [WIN_W-1:0]  win_len_i,
  input  logic signed [DATA_W-1:0] meas_i,
  output logic signed [DATA_W-1:0] exc_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic signed [ACC_W-1:0]  re_o,
  output logic signed [ACC_W-1:0]  im_o
);
  logic                     busy_q, done_q, adv, last;
  logic signed [DATA_W-1:0] sin_w, cos_w;
  logic signed [DATA_W-1:0] ref_w [LA_NCH];
  logic signed [ACC_W-1:0]  acc_w [LA_NCH];

  assign adv = sample_i && busy_q && !start_i;

  la_osc #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_osc (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(adv),
    .coef_i, .amp_i, .sin_o(sin_w), .cos_o(cos_w)
  );

  la_win #(.WIN_W(WIN_W)) u_win (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(adv),
    .len_i(win_len_i), .last_o(last)
  );

  assign ref_w[0] = sin_w;
  assign ref_w[1] = cos_w;

  for (genvar g = 0; g < LA_NCH; g++) begin : g_ch
    la_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
      .clk_i, .rst_ni, .clr_i(start_i), .en_i(adv),
      .a_i(meas_i), .b_i(ref_w[g]), .acc_o(acc_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv && last;
      if (start_i)          busy_q <= 1'b1;
      else if (adv && last) busy_q <= 1'b0;
    end
  end

  assign exc_o  = busy_q ? sin_w : '0;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign re_o   = acc_w[0];
  assign im_o   = acc_w[1];
endmodule

// File: rtl/loop_analyzer_chk.sv
module loop_analyzer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIN_W  = 12,
  parameter int unsigned ACC_W  = 44
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     sample_i,
  input logic        [WIN_W-1:0]  win_len_i,
  input logic signed [DATA_W-1:0] meas_i,
  input logic signed [DATA_W-1:0] exc_o,
  input logic                     busy_o,
  input logic                     done_o,
  input logic signed [ACC_W-1:0]  re_o,
  input logic signed [ACC_W-1:0]  im_o
);
  logic [WIN_W-1:0] n_q, w_q;
  logic             acc_ok;
  assign acc_ok = sample_i && busy_o && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      w_q <= '0;
    end else if (start_i) begin
      n_q <= '0;
      w_q <= win_len_i;
    end else if (acc_ok) begin
      n_q <= n_q + 1'b1;
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && exc_o == 0 && re_o == 0 && im_o == 0)); // R2

  AST_SILENT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sample_i && !start_i) |=> ($stable(re_o) && $stable(im_o) && $stable(exc_o))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> (longint'(re_o) == longint'($past(re_o)) + longint'($past(meas_i)) * longint'($past(exc_o)))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && n_q == w_q)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(re_o) && $stable(im_o) && exc_o == 0)); // R7
endmodule

bind loop_analyzer loop_analyzer_chk #(.DATA_W(DATA_W), .WIN_W(WIN_W), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sample_i(sample_i),
  .win_len_i(win_len_i), .meas_i(meas_i), .exc_o(exc_o), .busy_o(busy_o),
  .done_o(done_o), .re_o(re_o), .im_o(im_o)
);

// File: tb/loop_analyzer_test.sv
`timescale 1ns/1ps
module loop_analyzer_test;
  localparam int DW = 16;
  localparam int WW = 12;
  localparam int AW = 2 * DW + WW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sample = 1'b0;
  logic signed [DW-1:0] coef = '0, amp = '0, meas = '0;
  logic [WW-1:0] win = '0;
  logic signed [DW-1:0] exc;
  logic busy, done;
  logic signed [AW-1:0] re, im;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // model state
  logic signed [DW-1:0] m_s, m_c, m_k;
  longint m_re, m_im;
  int m_cnt, m_win;

  always #4 clk = ~clk;

  loop_analyzer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sample_i(sample),
    .coef_i(coef), .amp_i(amp), .win_len_i(win), .meas_i(meas),
    .exc_o(exc), .busy_o(busy), .done_o(done), .re_o(re), .im_o(im)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [DW-1:0] meas_of(input int mode, input int i);
    case (mode)
      0: return 16'sd3000;
      1: return (i % 2 == 0) ? 16'sd12000 : -16'sd9000;
      2: return 16'(i * 37 - 1000);
      default: return -16'sd32768;
    endcase
  endfunction

  task automatic show_summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R2 R4: start with settings, check cleared state
  task automatic begin_win(input int k, input int a, input int w);
    @(negedge clk);
    start = 1'b1; coef = 16'(k); amp = 16'(a); win = WW'(w);
    @(negedge clk);
    start = 1'b0;
    m_s = '0; m_c = 16'(a); m_k = 16'(k); m_re = 0; m_im = 0; m_cnt = 0; m_win = w;
    chk("R2 busy", longint'(busy), 1);
    chk("R2 exc", longint'(exc), 0);
    chk("R2 re", longint'(re), 0);
    chk("R2 im", longint'(im), 0);
  endtask

  // R3 R5 R6: feed n samples with optional idle gaps
  task automatic feed(input int n, input int mode, input int gap);
    for (int i = 0; i < n; i++) begin
      int kc, ks;
      meas = meas_of(mode, m_cnt);
      sample = 1'b1;
      chk("R3 exc", longint'(exc), longint'(m_s));
      @(negedge clk);
      sample = 1'b0;
      m_re += longint'(meas) * longint'(m_s);
      m_im += longint'(meas) * longint'(m_c);
      kc = int'(m_k) * int'(m_c);
      m_s = 16'(int'(m_s) + (kc >>> 14));
      ks = int'(m_k) * int'(m_s);
      m_c = 16'(int'(m_c) - (ks >>> 14));
      m_cnt++;
      chk("R6 done", longint'(done), (m_cnt == m_win) ? 1 : 0);
      chk("R6 busy", longint'(busy), (m_cnt == m_win) ? 0 : 1);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R5 gap re", longint'(re), m_re);
      end
    end
  endtask

  task automatic check_result(input string tag);
    chk({tag, " re"}, longint'(re), m_re);
    chk({tag, " im"}, longint'(im), m_im);
    @(negedge clk);
    chk("R6 pulse width", longint'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1 exc", longint'(exc), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 re", longint'(re), 0);
    chk("R1 im", longint'(im), 0);
  endtask

  task automatic t_basic();
    begin_win(800, 16384, 8);
    feed(8, 0, 0);
    check_result("R5 const");
    begin_win(-1500, 12000, 20);
    feed(20, 1, 2);
    check_result("R5 alt");
    begin_win(3000, 8000, 33);
    feed(33, 2, 1);
    check_result("R5 ramp");
  endtask

  task automatic t_idle();
    longint hr, hi;
    hr = re; hi = im;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      meas = 16'sd20000; sample = 1'b1;
      @(negedge clk);
      sample = 1'b0;
      chk("R7 exc idle", longint'(exc), 0);
    end
    chk("R7 re held", longint'(re), hr);
    chk("R7 im held", longint'(im), hi);
  endtask

  task automatic t_restart();
    begin_win(2000, 16000, 30);
    feed(5, 1, 0);
    begin_win(-700, 9000, 6);
    feed(6, 2, 0);
    check_result("R8 restart");
  endtask

  task automatic t_latch();
    begin_win(1200, 14000, 10);
    coef = 16'sd9000; amp = 16'sd100; win = 12'd2;
    feed(10, 1, 1);
    check_result("R4 latched");
  endtask

  task automatic t_full();
    begin_win(400, 16384, 4095);
    feed(4095, 3, 0);
    check_result("R9 full");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    show_summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_idle();
    t_restart();
    t_latch();
    t_full();
    repeat (3) @(negedge clk);
    show_summary();
  end
endmodule